// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block models a 32-bit-wide synchronous static RAM whose depth is set by an address-width parameter. Address, write data and all control inputs are sampled on the rising clock edge. Read data is not registered: once an address has been captured, the addressed word is driven combinationally from the array in that same cycle.

An access begins when either of two address strobes is low and the chip-select group is fully active. A 2-bit beat counter then produces three more word addresses inside the same aligned group of four. The order is linear or interleaved, chosen by a static mode pin. A separate advance input steps the counter or holds it. Writes cover the whole word under a global enable, or chosen byte lanes under a byte enable. A sleep input and an output enable act without waiting for the clock.

Top module: `burst_sram`

## Requirements
- R1: On a clock edge with a load, the word at the new address appears on `rdata` with `rvalid` high right after that edge. No further edge is needed.
- R2: With `lin_mode` low (interleaved), continuation beat n (n = 1..3) addresses the word whose low two address bits are start XOR n. The upper bits are those of the loaded address.
- R3: With `lin_mode` high (linear), beat n addresses low bits (start + n) mod 4. The upper address bits stay unchanged.
- R4: On a non-load edge with `adv_n` high, the current address is held and the same word stays on `rdata`.
- R5: A load takes place only when `ce_n`=0, `cs_hi`=1, `cs_lo_n`=0 and `adsp_n` or `adsc_n` is low. A strobe accepted while the selects are not all active deselects the device, and `rvalid` drops to 0.
- R6: `adsp_n` is ignored while `ce_n` is high. No load and no deselect take place, and the current word stays on the output.
- R7: `gw_n`=0 writes all four byte lanes with `wdata`, whatever `bwe_n` and `bsel_n` are.
- R8: With `gw_n`=1 and `bwe_n`=0, only lane i (bits 8i+7:8i) with `bsel_n[i]`=0 is written. The other lanes keep their old value.
- R9: With `gw_n`=1 and `bwe_n`=1, the cycle is a read and the array is not changed.
- R10: Write enables sampled on burst continuation edges write `wdata` to that beat's address.
- R11: While `sleep` is high, `rvalid` is 0 at once. No load, write or counter step happens on the edges it covers, and the previous word is visible again after `sleep` falls.
- R12: `oe_n`=1 forces `rvalid` to 0 at once. After a write cycle, `rvalid` is also 0. Whenever `rvalid` is 0, `rdata` is 0.
- R13: After reset the device is deselected: `rvalid`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Beat advance, active low |
| gw_n | input | 1 | Global (whole-word) write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low |
| lin_mode | input | 1 | 1 = linear beat order, 0 = interleaved |
| oe_n | input | 1 | Output enable, active low, unclocked |
| sleep | input | 1 | Power-down, unclocked |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Flow-through read data |
| rvalid | output | 1 | Read data valid |

## Verification
The bench sweeps all four start offsets in both beat orders and all sixteen byte-select patterns, and compares against an arithmetic model. A counter with the orders swapped, or with a carry into address bit 2, would read the wrong neighbour in the burst. A lane decode with reversed select polarity, or with global write not taking priority, would leave the wrong bytes in the array. It also targets the qualifiers: a processor strobe with chip enable high, a strobe under a partial select, and a write attempted during sleep. A design that loaded, deselected or wrote in those cases would show a changed or missing word on the next readback. An output gated through a register instead of directly would show up as a one-cycle lag on the first beat or on the output-enable response.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // low two address bits of beat number `beat` from start offset `start`
  function automatic logic [1:0] beat_lo(logic [1:0] start, logic [1:0] beat, logic lin);
    if (lin) return start + beat;
    return start ^ beat;
  endfunction

  // byte lanes enabled by the write controls; zero means a read cycle
  function automatic logic [LANES-1:0] lane_mask(logic gw_n, logic bwe_n,
                                                 logic [LANES-1:0] bsel_n);
    if (!gw_n)  return {LANES{1'b1}};
    if (!bwe_n) return ~bsel_n;
    return '0;
  endfunction
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             oe_n,
  input  logic             sleep,
  output logic             load_ev,
  output logic             desel_ev,
  output logic             cont_ev,
  output logic             step_ev,
  output logic [LANES-1:0] wr_mask,
  output logic             active_q,
  output logic             rvalid
);
  logic sel_all, strobe_seen, no_strobe, rd_q;
  logic [LANES-1:0] mask_raw;

  assign sel_all     = !ce_n && cs_hi && !cs_lo_n;
  // processor strobe only counts while chip enable is active
  assign strobe_seen = !adsc_n || (!adsp_n && !ce_n);
  assign no_strobe   = !strobe_seen;

  assign load_ev  = !sleep && strobe_seen && sel_all;
  assign desel_ev = !sleep && strobe_seen && !sel_all;
  assign cont_ev  = !sleep && no_strobe && active_q;
  assign step_ev  = cont_ev && !adv_n;

  assign mask_raw = lane_mask(gw_n, bwe_n, bsel_n);
  assign wr_mask  = (load_ev || cont_ev) ? mask_raw : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (load_ev)       active_q <= 1'b1;
      else if (desel_ev) active_q <= 1'b0;
      if (load_ev || cont_ev) rd_q <= (mask_raw == '0);
    end
  end

  assign rvalid = active_q && rd_q && !oe_n && !sleep;
endmodule

// File: rtl/sram_burst.sv
module sram_burst
  import sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lin_mode,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;
  logic [1:0]    beat_nx;

  assign beat_nx  = beat_q + 2'd1;
  assign cur_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], beat_q, lin_mode)};

  always_comb begin
    if (load)      next_addr = addr_in;
    else if (step) next_addr = {base_q[AW-1:2], beat_lo(base_q[1:0], beat_nx, lin_mode)};
    else           next_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_nx;
    end
  end
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bsel_n,
  input  logic              lin_mode,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic             load_ev, desel_ev, cont_ev, step_ev, active_q;
  logic [LANES-1:0] wr_mask;
  logic [AW-1:0]    cur_addr, next_addr;
  logic [WORD_W-1:0] rword;

  sram_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep),
    .load_ev(load_ev), .desel_ev(desel_ev), .cont_ev(cont_ev),
    .step_ev(step_ev), .wr_mask(wr_mask), .active_q(active_q), .rvalid(rvalid)
  );

  sram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .load(load_ev),
    .step(step_ev), .addr_in(addr), .cur_addr(cur_addr), .next_addr(next_addr)
  );

  sram_array #(.AW(AW)) u_array (
    .clk(clk), .we(wr_mask), .waddr(next_addr), .wdata(wdata),
    .raddr(cur_addr), .rword(rword)
  );

  assign rdata = rvalid ? rword : '0;
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          ce_n,
  input logic          adsp_n,
  input logic          adsc_n,
  input logic          adv_n,
  input logic          gw_n,
  input logic          oe_n,
  input logic          sleep,
  input logic          rvalid,
  input logic          load_ev,
  input logic          desel_ev,
  input logic          cont_ev,
  input logic          step_ev,
  input logic [3:0]    wr_mask,
  input logic          active_q,
  input logic [AW-1:0] cur_addr
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> cur_addr == $past(addr)); // R5
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ev, desel_ev, cont_ev})); // R5
  AST_DESEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    desel_ev |=> !active_q && !rvalid); // R5
  AST_ADSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && adsc_n) |-> !load_ev && !desel_ev); // R6
  AST_ADV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && (adsp_n || ce_n) && adv_n) |=> $stable(cur_addr)); // R4
  AST_STEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R3
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && (load_ev || cont_ev)) |-> wr_mask == 4'hF); // R7
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(cur_addr) && $stable(active_q)); // R11
  AST_SLEEP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> wr_mask == 4'h0); // R11
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || sleep) |-> !rvalid); // R12
endmodule

bind burst_sram sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .adsp_n(adsp_n),
  .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .oe_n(oe_n), .sleep(sleep),
  .rvalid(rvalid), .load_ev(load_ev), .desel_ev(desel_ev), .cont_ev(cont_ev),
  .step_ev(step_ev), .wr_mask(wr_mask), .active_q(active_q), .cur_addr(cur_addr)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b0, cs_hi = 1'b1, cs_lo_n = 1'b0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bsel_n = 4'hF;
  logic lin_mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] model [0:63];

  always #10 clk = ~clk;

  burst_sram #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .lin_mode(lin_mode),
    .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [31:0] pat(int a, int salt);
    return (a * 32'h9E3779B1) ^ (salt * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  function automatic int beat_addr(int start, int n, logic lin);
    int lo;
    lo = lin ? ((start % 4) + n) % 4 : ((start % 4) ^ n);
    return (start / 4) * 4 + lo;
  endfunction

  // bench-side write: merge lanes into model
  task automatic apply_model(int a, logic g, logic b, logic [3:0] s, logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !s[i])) model[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic write_word(int a, logic g, logic b, logic [3:0] s, logic [31:0] d);
    addr = AW'(a); adsc_n = 1'b0; gw_n = g; bwe_n = b; bsel_n = s; wdata = d;
    tick();
    adsc_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
    apply_model(a, g, b, s, d);
  endtask

  task automatic load_read(string req, int a, logic use_p);
    addr = AW'(a);
    if (use_p) adsp_n = 1'b0; else adsc_n = 1'b0;
    tick();
    adsp_n = 1'b1; adsc_n = 1'b1;
    check(req, rdata, model[a]);
    check(req, {31'd0, rvalid}, 32'd1);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    tick();
    // R13: reset state
    check("R13 rvalid", {31'd0, rvalid}, 32'd0);
    check("R13 rdata", rdata, 32'd0);

    // R7: fill with global writes (bwe/bsel deliberately asserted too)
    for (int a = 0; a < 64; a++) begin
      write_word(a, 1'b0, 1'b0, 4'hA, pat(a, 1));
      check("R12 write cycle rvalid", {31'd0, rvalid}, 32'd0);
    end
    for (int a = 0; a < 64; a += 7) load_read("R7 R1", a, a[0]);

    // R2 R3: all start offsets, both orders
    for (int m = 0; m < 2; m++) begin
      lin_mode = m[0];
      for (int b = 0; b < 3; b++) begin
        for (int s = 0; s < 4; s++) begin
          int st;
          st = b * 20 + s;
          st = (st / 4) * 4 + s;
          load_read("R1 first beat", st, s[0]);
          for (int n = 1; n < 4; n++) begin
            adv_n = 1'b0; tick(); adv_n = 1'b1;
            check(m ? "R3 linear beat" : "R2 interleaved beat", rdata,
                  model[beat_addr(st, n, m[0])]);
          end
        end
      end
    end

    // R4: advance held high keeps the word
    lin_mode = 1'b1;
    load_read("R4 load", 13, 1'b0);
    tick();
    check("R4 hold", rdata, model[13]);
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    check("R4 then step", rdata, model[14]);

    // R8: every byte-select pattern
    for (int k = 0; k < 16; k++) begin
      write_word(32 + k, 1'b1, 1'b0, 4'(~k), pat(k, 7));
      load_read("R8 lane write", 32 + k, 1'b0);
    end
    // R9: neither write enable -> array untouched
    write_word(40, 1'b1, 1'b1, 4'h0, 32'hDEADBEEF);
    check("R9 read cycle rvalid", {31'd0, rvalid}, 32'd1);
    load_read("R9 unchanged", 40, 1'b1);

    // R10: burst write, interleaved, start offset 2
    lin_mode = 1'b0;
    addr = AW'(50); adsc_n = 1'b0; gw_n = 1'b0; wdata = pat(50, 9);
    tick(); adsc_n = 1'b1;
    apply_model(50, 1'b0, 1'b1, 4'hF, pat(50, 9));
    for (int n = 1; n < 4; n++) begin
      adv_n = 1'b0; wdata = pat(n, 11);
      tick();
      apply_model(beat_addr(50, n, 1'b0), 1'b0, 1'b1, 4'hF, pat(n, 11));
    end
    adv_n = 1'b1; gw_n = 1'b1;
    for (int w = 48; w < 52; w++) load_read("R10 burst write", w, 1'b0);

    // R6: processor strobe ignored with chip enable high
    load_read("R6 setup", 8, 1'b0);
    ce_n = 1'b1; adsp_n = 1'b0; addr = AW'(20);
    tick();
    check("R6 ignored word", rdata, model[8]);
    check("R6 ignored valid", {31'd0, rvalid}, 32'd1);
    adsp_n = 1'b1;
    // R5: controller strobe with ce_n high deselects
    adsc_n = 1'b0; tick(); adsc_n = 1'b1;
    check("R5 deselect valid", {31'd0, rvalid}, 32'd0);
    check("R5 deselect data", rdata, 32'd0);
    ce_n = 1'b0;
    // R5: write under partial select does nothing
    cs_hi = 1'b0;
    addr = AW'(5); adsc_n = 1'b0; gw_n = 1'b0; wdata = 32'h12345678;
    tick(); adsc_n = 1'b1; gw_n = 1'b1; cs_hi = 1'b1;
    check("R5 cs_hi low", {31'd0, rvalid}, 32'd0);
    cs_lo_n = 1'b1; adsp_n = 1'b0; tick(); adsp_n = 1'b1; cs_lo_n = 1'b0;
    check("R5 cs_lo_n high", {31'd0, rvalid}, 32'd0);
    load_read("R5 no write", 5, 1'b1);

    // R11: sleep
    load_read("R11 setup", 9, 1'b0);
    sleep = 1'b1; #1;
    check("R11 async valid", {31'd0, rvalid}, 32'd0);
    addr = AW'(10); adsc_n = 1'b0; gw_n = 1'b0; wdata = 32'hCAFEF00D;
    tick(); adsc_n = 1'b1; gw_n = 1'b1;
    adv_n = 1'b0; tick(); adv_n = 1'b1;
    sleep = 1'b0; #1;
    check("R11 resume word", rdata, model[9]);
    check("R11 resume valid", {31'd0, rvalid}, 32'd1);
    load_read("R11 no write", 10, 1'b0);

    // R12: output enable
    load_read("R12 setup", 11, 1'b1);
    oe_n = 1'b1; #1;
    check("R12 oe valid", {31'd0, rvalid}, 32'd0);
    check("R12 oe data", rdata, 32'd0);
    oe_n = 1'b0; #1;
    check("R12 oe back", rdata, model[11]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule